// File: doc/BRIEF.md
# DMA Window Address Translator

This block turns addresses seen on a PCI bus into physical memory addresses for DMA. It holds four address windows. Each window has a base register, a size mask and a target base, and all of them are 64 bits wide. Software loads these twelve registers through a small indexed register port, and the block has no other means of reaching them.

A separate lookup port accepts one bus address per cycle. The window logic compares the address with every window at once. A priority picker then takes the lowest-numbered window that is enabled and matches. For a direct-mapped window, the physical address is the target base with the window's offset bits replaced by the same bits of the bus address. A window marked for scatter-gather is not translated: the lookup reports it as unsupported. Every result comes back one cycle after its request with exactly one of three flags set (hit, miss, scatter-gather error), so a genuine physical address of zero can be told apart from a miss.

Top module: `dma_xlat`

## Requirements
- R1: After a synchronous active-high reset, all twelve window registers read as zero, `lk_valid` and `reg_rvalid` are low, and a lookup returns a miss.
- R2: Register index bits [3:2] select the register kind: 0 = window base, 1 = size mask, 2 = target base. Index bits [1:0] select the window. A read returns the stored 64-bit value with `reg_rvalid` high in the cycle after `reg_rd_en`.
- R3: Indices 12 to 15 are unmapped. A write to one of them changes no register, and a read of one returns zero.
- R4: A window matches when the bus address equals the window base on every bit of 30:20 whose mask bit is 0. Mask bits outside 30:20 have no effect, and bus address bits above 30 are neither compared nor passed through.
- R5: Window base bit 0 enables the window. A disabled window never produces a result, even when it matches and even when its bit 1 is set, and the search goes on to the later windows.
- R6: When several enabled windows match, the one with the lowest index decides the result.
- R7: On a direct hit, the pass-through mask is mask bits 30:20 plus bits 19:0. The physical address is the target base with the pass-through bits cleared, ORed with the bus address bits under the pass-through mask, and `lk_hit` is high.
- R8: If the deciding window has base bit 1 set (scatter-gather), the result raises `lk_sg_err` instead of `lk_hit`, and the physical address is zero.
- R9: When no enabled window matches, `lk_miss` is high and the physical address is zero.
- R10: Each cycle with `lk_req` high yields `lk_valid` in the next cycle, with exactly one of `lk_hit`, `lk_miss` and `lk_sg_err` high. Outside valid cycles all three flags are low. A lookup uses the register contents from before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_idx | input | 4 | Register index: kind in [3:2], window in [1:0] |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd_en |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Bus address to translate |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Direct-mapped translation produced |
| lk_miss | output | 1 | No enabled window matched |
| lk_sg_err | output | 1 | Deciding window is in scatter-gather mode |
| lk_paddr | output | 64 | Translated physical address, zero unless hit |

## Verification
The bench sets windows up to overlap, and a design that picked the highest index or the last match would return the wrong window's address. It disables a window that matches, including one with scatter-gather set, to catch a design that stops searching early or reports an error from a disabled window. It fills the mask bits outside 30:20 with ones and sets bus address bit 31, so a design that widened the compare or the pass-through would produce a wrong address or a miss. Finally, it translates to a true zero address and reads back after writes to the unmapped indices, which exposes a design that confuses a zero address with a miss or decodes the index loosely.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;

  // Register kind carried in the upper two bits of the register index.
  typedef enum logic [1:0] {
    KIND_BASE  = 2'd0,
    KIND_MASK  = 2'd1,
    KIND_TBASE = 2'd2,
    KIND_NONE  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic hit;
    logic miss;
    logic sg_err;
  } lk_flags_t;

endpackage

// File: rtl/dma_xlat_regs.sv
module dma_xlat_regs
  import dma_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 64,
  localparam int WIN_W  = $clog2(NUM_WIN),
  localparam int IDX_W  = WIN_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] base_o  [NUM_WIN],
  output logic [DATA_W-1:0] mask_o  [NUM_WIN],
  output logic [DATA_W-1:0] tbase_o [NUM_WIN]
);

  reg_kind_e        kind;
  logic [WIN_W-1:0] win;

  assign kind = reg_kind_e'(idx[IDX_W-1:WIN_W]);
  assign win  = idx[WIN_W-1:0];

  logic [DATA_W-1:0] base_q  [NUM_WIN];
  logic [DATA_W-1:0] mask_q  [NUM_WIN];
  logic [DATA_W-1:0] tbase_q [NUM_WIN];

  // One storage slice per window; an unmapped kind writes nothing.
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[w]  <= '0;
        mask_q[w]  <= '0;
        tbase_q[w] <= '0;
      end else if (wr_en && win == WIN_W'(w)) begin
        case (kind)
          KIND_BASE:  base_q[w]  <= wdata;
          KIND_MASK:  mask_q[w]  <= wdata;
          KIND_TBASE: tbase_q[w] <= wdata;
          default:    ;
        endcase
      end
    end

    assign base_o[w]  = base_q[w];
    assign mask_o[w]  = mask_q[w];
    assign tbase_o[w] = tbase_q[w];
  end

  // Registered read path.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        case (kind)
          KIND_BASE:  rdata <= base_q[win];
          KIND_MASK:  rdata <= mask_q[win];
          KIND_TBASE: rdata <= tbase_q[win];
          default:    rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_xlat_win.sv
module dma_xlat_win #(
  parameter int BUS_AW = 32,
  parameter int DATA_W = 64,
  parameter int CMP_LO = 20,
  parameter int CMP_HI = 30,
  localparam int CMP_W = CMP_HI - CMP_LO + 1
) (
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] tbase_i,
  output logic              match_o,
  output logic              sg_o,
  output logic [DATA_W-1:0] paddr_o
);

  logic [CMP_W-1:0]  care;
  logic [CMP_W-1:0]  diff;
  logic [DATA_W-1:0] pass;
  logic [DATA_W-1:0] addr_ext;
  logic              unused_bits;

  assign care = ~mask_i[CMP_HI:CMP_LO];
  assign diff = addr_i[CMP_HI:CMP_LO] ^ base_i[CMP_HI:CMP_LO];

  always_comb begin
    pass                 = '0;
    pass[CMP_HI:CMP_LO]  = mask_i[CMP_HI:CMP_LO];
    pass[CMP_LO-1:0]     = '1;
    addr_ext             = '0;
    addr_ext[BUS_AW-1:0] = addr_i;
  end

  assign match_o = base_i[0] && ((diff & care) == '0);
  assign sg_o    = base_i[1];
  assign paddr_o = (tbase_i & ~pass) | (addr_ext & pass);

  assign unused_bits = ^{base_i[DATA_W-1:CMP_HI+1], base_i[CMP_LO-1:2],
                         mask_i[DATA_W-1:CMP_HI+1], mask_i[CMP_LO-1:0]};

endmodule

// File: rtl/dma_xlat_pick.sv
module dma_xlat_pick
  import dma_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 64
) (
  input  logic [NUM_WIN-1:0] match_i,
  input  logic [NUM_WIN-1:0] sg_i,
  input  logic [DATA_W-1:0]  paddr_i [NUM_WIN],
  output lk_flags_t          flags_o,
  output logic [DATA_W-1:0]  paddr_o
);

  logic              found;
  logic              sel_sg;
  logic [DATA_W-1:0] sel_pa;

  // Scan from the top so the lowest matching index is the last to assign.
  always_comb begin
    found  = 1'b0;
    sel_sg = 1'b0;
    sel_pa = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        found  = 1'b1;
        sel_sg = sg_i[i];
        sel_pa = paddr_i[i];
      end
    end
    flags_o.hit    = found & ~sel_sg;
    flags_o.miss   = ~found;
    flags_o.sg_err = found & sel_sg;
    paddr_o        = (found && !sel_sg) ? sel_pa : '0;
  end

endmodule

// File: rtl/dma_xlat.sv
module dma_xlat
  import dma_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 64,
  parameter int BUS_AW  = 32,
  parameter int CMP_LO  = 20,
  parameter int CMP_HI  = 30,
  localparam int WIN_W  = $clog2(NUM_WIN),
  localparam int IDX_W  = WIN_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              lk_req,
  input  logic [BUS_AW-1:0] lk_addr,
  output logic              lk_valid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_sg_err,
  output logic [DATA_W-1:0] lk_paddr
);

  logic [DATA_W-1:0]  base  [NUM_WIN];
  logic [DATA_W-1:0]  mask  [NUM_WIN];
  logic [DATA_W-1:0]  tbase [NUM_WIN];
  logic [NUM_WIN-1:0] win_match;
  logic [NUM_WIN-1:0] win_sg;
  logic [DATA_W-1:0]  win_pa [NUM_WIN];
  lk_flags_t          pick_flags;
  logic [DATA_W-1:0]  pick_pa;

  dma_xlat_regs #(
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .rd_en   (reg_rd_en),
    .idx     (reg_idx),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .rvalid  (reg_rvalid),
    .base_o  (base),
    .mask_o  (mask),
    .tbase_o (tbase)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    dma_xlat_win #(
      .BUS_AW (BUS_AW),
      .DATA_W (DATA_W),
      .CMP_LO (CMP_LO),
      .CMP_HI (CMP_HI)
    ) u_win (
      .addr_i  (lk_addr),
      .base_i  (base[w]),
      .mask_i  (mask[w]),
      .tbase_i (tbase[w]),
      .match_o (win_match[w]),
      .sg_o    (win_sg[w]),
      .paddr_o (win_pa[w])
    );
  end

  dma_xlat_pick #(
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W)
  ) u_pick (
    .match_i (win_match),
    .sg_i    (win_sg),
    .paddr_i (win_pa),
    .flags_o (pick_flags),
    .paddr_o (pick_pa)
  );

  // Result register: one cycle from request to valid.
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid  <= 1'b0;
      lk_hit    <= 1'b0;
      lk_miss   <= 1'b0;
      lk_sg_err <= 1'b0;
      lk_paddr  <= '0;
    end else begin
      lk_valid  <= lk_req;
      lk_hit    <= lk_req & pick_flags.hit;
      lk_miss   <= lk_req & pick_flags.miss;
      lk_sg_err <= lk_req & pick_flags.sg_err;
      lk_paddr  <= lk_req ? pick_pa : '0;
    end
  end

endmodule

// File: rtl/dma_xlat_chk.sv
module dma_xlat_chk #(
  parameter int WIN_W  = 2,
  parameter int DATA_W = 64,
  parameter int BUS_AW = 32,
  parameter int CMP_LO = 20,
  localparam int IDX_W = WIN_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd_en,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reg_rvalid,
  input logic              lk_req,
  input logic [BUS_AW-1:0] lk_addr,
  input logic              lk_valid,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic              lk_sg_err,
  input logic [DATA_W-1:0] lk_paddr
);

  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> reg_rvalid);

  a_r3_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_idx[IDX_W-1:WIN_W] == 2'b11) |=> (reg_rdata == '0));

  a_r7_offset_passes: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[CMP_LO-1:0] == $past(lk_addr[CMP_LO-1:0])));

  a_r8_sg_no_address: assert property (@(posedge clk) disable iff (rst)
    lk_sg_err |-> (lk_paddr == '0));

  a_r9_miss_no_address: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (lk_paddr == '0));

  a_r10_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_valid);

  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_valid);

  a_r10_one_flag: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> ($countones({lk_hit, lk_miss, lk_sg_err}) == 1));

  a_r10_quiet_flags: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> ({lk_hit, lk_miss, lk_sg_err} == 3'b000));

endmodule

bind dma_xlat dma_xlat_chk #(
  .WIN_W  (WIN_W),
  .DATA_W (DATA_W),
  .BUS_AW (BUS_AW),
  .CMP_LO (CMP_LO)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_rd_en  (reg_rd_en),
  .reg_idx    (reg_idx),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .lk_req     (lk_req),
  .lk_addr    (lk_addr),
  .lk_valid   (lk_valid),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_sg_err  (lk_sg_err),
  .lk_paddr   (lk_paddr)
);

// File: tb/dma_xlat_bench.sv
`timescale 1ns/1ps
module dma_xlat_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        reg_rvalid;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_valid, lk_hit, lk_miss, lk_sg_err;
  logic [63:0] lk_paddr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_xlat u_dma_xlat (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_valid(lk_valid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_sg_err(lk_sg_err),
    .lk_paddr(lk_paddr)
  );

  typedef struct {
    logic [2:0]  flags;   // {hit, miss, sg_err}
    logic [63:0] pa;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] sh_base [4];
  logic [63:0] sh_mask [4];
  logic [63:0] sh_tb   [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [2:0] f, input logic [63:0] pa, input string tag);
    exp_t e;
    e.flags = f;
    e.pa    = pa;
    e.tag   = tag;
    return e;
  endfunction

  // Reference model written from R4..R9.
  function automatic exp_t model(input logic [31:0] a, input string tag);
    logic [63:0] pm;
    for (int i = 0; i < 4; i++) begin
      if (sh_base[i][0] &&
          (((a[30:20] ^ sh_base[i][30:20]) & ~sh_mask[i][30:20]) == 11'd0)) begin
        if (sh_base[i][1]) return mk(3'b001, 64'd0, tag);
        pm = {33'd0, sh_mask[i][30:20], 20'hFFFFF};
        return mk(3'b100, (sh_tb[i] & ~pm) | ({32'd0, a} & pm), tag);
      end
    end
    return mk(3'b010, 64'd0, tag);
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_idx   = idx;
    reg_wdata = d;
    case (idx[3:2])
      2'd0: sh_base[idx[1:0]] = d;
      2'd1: sh_mask[idx[1:0]] = d;
      2'd2: sh_tb[idx[1:0]]   = d;
      default: ;
    endcase
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [63:0] exp, input string req);
    @(negedge clk);
    reg_rd_en = 1'b1;
    reg_idx   = idx;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(reg_rvalid === 1'b1, req, $sformatf("rvalid idx %0d", idx), {63'd0, reg_rvalid}, 64'd1);
    check(reg_rdata === exp, req, $sformatf("rdata idx %0d", idx), reg_rdata, exp);
  endtask

  // Driver: one request per call, back-to-back when called in sequence.
  task automatic lk(input logic [31:0] a, input exp_t e);
    @(negedge clk);
    lk_req  = 1'b1;
    lk_addr = a;
    sb_q.push_back(e);
  endtask

  task automatic lk_stop();
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  // Monitor: compares each valid result with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && lk_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10", "unexpected valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({lk_hit, lk_miss, lk_sg_err} === e.flags, e.tag, "flags {hit,miss,sg}",
              {61'd0, lk_hit, lk_miss, lk_sg_err}, {61'd0, e.flags});
        check(lk_paddr === e.pa, e.tag, "paddr", lk_paddr, e.pa);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      sh_base[i] = '0; sh_mask[i] = '0; sh_tb[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(lk_valid === 1'b0, "R1", "lk_valid after reset", {63'd0, lk_valid}, 64'd0);
    check(reg_rvalid === 1'b0, "R1", "rvalid after reset", {63'd0, reg_rvalid}, 64'd0);
    for (int i = 0; i < 12; i++) rd(4'(i), 64'd0, "R1");
    lk(32'h4000_0000, mk(3'b010, 64'd0, "R1"));
    lk_stop();

    // R2: every register holds its own pattern
    for (int i = 0; i < 12; i++)
      wr(4'(i), {32'hC0DE_0000 + 32'(i), 32'h1234_5678 ^ 32'(i * 32'h0101_0101)});
    for (int i = 0; i < 12; i++)
      rd(4'(i), {32'hC0DE_0000 + 32'(i), 32'h1234_5678 ^ 32'(i * 32'h0101_0101)}, "R2");

    // R3: unmapped indices
    wr(4'd13, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(4'd12, 64'hDEAD_BEEF_DEAD_BEEF);
    rd(4'd13, 64'd0, "R3");
    rd(4'd15, 64'd0, "R3");
    for (int i = 0; i < 12; i++)
      rd(4'(i), {32'hC0DE_0000 + 32'(i), 32'h1234_5678 ^ 32'(i * 32'h0101_0101)}, "R3");

    // Window 0 only: 4 MB window at 0x4000_0000
    for (int i = 1; i < 4; i++) wr(4'(i), 64'd0);
    wr(4'd0, 64'h4000_0001);
    wr(4'd4, 64'h0030_0000);
    wr(4'd8, 64'h1_2340_0000);
    lk(32'h4012_3456, mk(3'b100, 64'h1_2352_3456, "R7"));
    lk(32'h4052_0000, mk(3'b010, 64'd0, "R9"));
    lk_stop();
    // R10: timing of a single lookup
    lk(32'h4000_0010, mk(3'b100, 64'h1_2340_0010, "R10"));
    @(negedge clk);
    lk_req = 1'b0;
    check(lk_valid === 1'b1, "R10", "valid one cycle after req", {63'd0, lk_valid}, 64'd1);
    @(negedge clk);
    check(lk_valid === 1'b0, "R10", "valid drops after idle", {63'd0, lk_valid}, 64'd0);

    // R4: mask bits outside 30:20 and bus bit 31 have no effect
    wr(4'd4, 64'hFFFF_FFFF_803F_FFFF);
    lk(32'h4012_3456, mk(3'b100, 64'h1_2352_3456, "R4"));
    lk(32'hC012_3456, mk(3'b100, 64'h1_2352_3456, "R4"));
    lk_stop();

    // R5: disabled matching window is skipped
    wr(4'd1, 64'h4000_0001);
    wr(4'd5, 64'h0070_0000);
    wr(4'd9, 64'h8000_0000);
    wr(4'd0, 64'h4000_0000);
    lk(32'h4012_3456, mk(3'b100, 64'h8012_3456, "R5"));
    lk_stop();

    // R6: lowest enabled index wins
    wr(4'd0, 64'h4000_0001);
    lk(32'h4012_3456, mk(3'b100, 64'h1_2352_3456, "R6"));
    lk(32'h4052_3456, mk(3'b100, 64'h8052_3456, "R6"));
    lk_stop();

    // R8: scatter-gather window, ahead of a direct one
    wr(4'd2, 64'h2000_0003);
    wr(4'd6, 64'h0);
    wr(4'd3, 64'h2000_0001);
    wr(4'd7, 64'h0);
    wr(4'd11, 64'h5_0000_0000);
    lk(32'h2000_1000, mk(3'b001, 64'd0, "R8"));
    lk_stop();
    // R5: disabled scatter-gather window reports nothing
    wr(4'd2, 64'h2000_0002);
    lk(32'h2000_1000, mk(3'b100, 64'h5_0000_1000, "R5"));
    lk(32'h1000_0000, mk(3'b010, 64'd0, "R9"));
    lk_stop();

    // R10: a true zero address is a hit, not a miss
    wr(4'd3, 64'h1);
    wr(4'd11, 64'h0);
    lk(32'h0000_0ABC, mk(3'b100, 64'h0ABC, "R10"));
    lk(32'h0000_0000, mk(3'b100, 64'h0, "R10"));
    lk_stop();

    // Sweep against the model, back to back
    wr(4'd2, 64'h2000_0003);
    for (int i = 0; i < 48; i++) begin
      logic [31:0] a;
      a = 32'(i) * 32'h0230_1117;
      lk(a, model(a, "R6"));
    end
    lk_stop();

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R10", "all lookups answered", 64'(sb_q.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule